// File: doc/BRIEF.md
# Direct-Segment Address Translator with Word Interleaving

This block sits in the address path of a memory controller. Each request carries a host virtual byte address. The block checks the address against one large direct segment, described by a base, a limit and an offset. An address inside the window is relocated with a single addition and needs no table walk. Any other address is passed on unchanged. A request inside the segment is also reported as non-cacheable.

The block also decides how the 64-bit word that holds the byte is laid out over the chips of the rank.

- **Outside the segment:** the usual mapping applies. Every chip holds one byte lane of every word.
- **Inside the segment:** a word is kept whole in one chip, and consecutive words rotate through the chips. An in-memory compute engine in a chip can then see complete operands.

Because a word no longer arrives spread over the whole data bus, critical-word-first burst ordering is disallowed for segment accesses. The result appears one clock after the request, with a valid strobe.

Top module: `seg_xlate`

## Requirements
- R1: After reset, and until the first accepted request, out_valid is 0 and every other output is 0.
- R2: out_valid equals in_valid of the previous cycle. The data outputs are loaded only in a cycle with in_valid high, and they hold their value in cycles with in_valid low.
- R3: A request is inside the segment exactly when cfg_base <= in_vaddr < cfg_limit, compared as unsigned numbers. out_inseg is then 1, meaning the access is non-cacheable; otherwise it is 0.
- R4: Inside the segment, out_paddr = (in_vaddr + cfg_offset) modulo 2^ADDR_W.
- R5: Outside the segment, out_paddr = in_vaddr.
- R6: Outside the segment, the byte-lane layout applies:
  - out_chip_mask is all ones (bit k selects chip k);
  - out_chip_sel = out_paddr[2:0], the chip that holds the addressed byte;
  - out_chip_addr = out_paddr >> 3.
- R7: Inside the segment, the whole-word layout applies:
  - out_chip_sel = out_paddr[5:3];
  - out_chip_mask has only bit out_chip_sel set;
  - out_chip_addr = out_paddr >> 6, zero-extended.
- R8: out_cwf_ok, which permits critical-word-first burst order, is 1 exactly when out_inseg is 0.
- R9: When cfg_limit <= cfg_base the segment is empty: no address is inside it, and every request is passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_vaddr | input | ADDR_W | Virtual byte address |
| cfg_base | input | ADDR_W | First address of the segment |
| cfg_limit | input | ADDR_W | First address past the segment |
| cfg_offset | input | ADDR_W | Relocation added inside the segment |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_paddr | output | ADDR_W | Physical byte address |
| out_inseg | output | 1 | Inside the segment, non-cacheable |
| out_cwf_ok | output | 1 | Critical-word-first order permitted |
| out_chip_mask | output | WORD_BYTES | Chips taking part in the word transfer |
| out_chip_sel | output | log2(WORD_BYTES) | Chip holding the addressed byte |
| out_chip_addr | output | ADDR_W-log2(WORD_BYTES) | Word address inside the chip |

## Verification
The bench builds the block with ADDR_W = 10 and the default 8-byte word. This makes every one of the 1024 addresses reachable in one sweep for each segment setting.

The settings exercised are:
- a window whose relocation wraps past the top of the address space;
- a window that starts at zero and stops one address short of the top;
- an empty window and an inverted window.

Together these cover both window edges, the modulo addition, the rotation through every chip, and the hold behaviour when no request is presented.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic {
    MAP_BYTE_LANES = 1'b0,
    MAP_WHOLE_WORD = 1'b1
  } map_mode_e;
endpackage

// File: rtl/seg_range_chk.sv
module seg_range_chk #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              hit
);
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  assign hit = in_window(vaddr, base, limit);
endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [ADDR_W-1:0] offset,
  input  logic              hit,
  output logic [ADDR_W-1:0] paddr
);
  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] ofs);
    return a + ofs;
  endfunction

  assign paddr = hit ? relocate(vaddr, offset) : vaddr;
endmodule

// File: rtl/seg_lane_map.sv
module seg_lane_map
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  localparam int BYTE_W    = $clog2(WORD_BYTES),
  localparam int CA_W      = ADDR_W - BYTE_W
) (
  input  logic [ADDR_W-1:0]     paddr,
  input  map_mode_e             mode,
  output logic [WORD_BYTES-1:0] chip_mask,
  output logic [BYTE_W-1:0]     chip_sel,
  output logic [CA_W-1:0]       chip_addr
);
  localparam int WORD_SH = 2 * BYTE_W;

  function automatic logic [CA_W-1:0] word_in_chip(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] sh;
    sh = a >> WORD_SH;
    return sh[CA_W-1:0];
  endfunction

  always_comb begin
    if (mode == MAP_WHOLE_WORD) begin
      chip_sel  = paddr[WORD_SH-1:BYTE_W];
      chip_addr = word_in_chip(paddr);
    end else begin
      chip_sel  = paddr[BYTE_W-1:0];
      chip_addr = paddr[ADDR_W-1:BYTE_W];
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_mask
    assign chip_mask[g] = (mode == MAP_BYTE_LANES) || (chip_sel == BYTE_W'(g));
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  localparam int BYTE_W    = $clog2(WORD_BYTES),
  localparam int CA_W      = ADDR_W - BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [ADDR_W-1:0]     in_vaddr,
  input  logic [ADDR_W-1:0]     cfg_base,
  input  logic [ADDR_W-1:0]     cfg_limit,
  input  logic [ADDR_W-1:0]     cfg_offset,
  output logic                  out_valid,
  output logic [ADDR_W-1:0]     out_paddr,
  output logic                  out_inseg,
  output logic                  out_cwf_ok,
  output logic [WORD_BYTES-1:0] out_chip_mask,
  output logic [BYTE_W-1:0]     out_chip_sel,
  output logic [CA_W-1:0]       out_chip_addr
);
  logic                  seg_hit;
  logic [ADDR_W-1:0]     nxt_paddr;
  map_mode_e             nxt_mode;
  logic [WORD_BYTES-1:0] nxt_mask;
  logic [BYTE_W-1:0]     nxt_sel;
  logic [CA_W-1:0]       nxt_caddr;

  seg_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .vaddr(in_vaddr), .base(cfg_base), .limit(cfg_limit), .hit(seg_hit)
  );

  seg_addr_add #(.ADDR_W(ADDR_W)) u_add (
    .vaddr(in_vaddr), .offset(cfg_offset), .hit(seg_hit), .paddr(nxt_paddr)
  );

  assign nxt_mode = seg_hit ? MAP_WHOLE_WORD : MAP_BYTE_LANES;

  seg_lane_map #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_map (
    .paddr(nxt_paddr), .mode(nxt_mode),
    .chip_mask(nxt_mask), .chip_sel(nxt_sel), .chip_addr(nxt_caddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_paddr     <= '0;
      out_inseg     <= 1'b0;
      out_cwf_ok    <= 1'b0;
      out_chip_mask <= '0;
      out_chip_sel  <= '0;
      out_chip_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_paddr     <= nxt_paddr;
        out_inseg     <= seg_hit;
        out_cwf_ok    <= !seg_hit;
        out_chip_mask <= nxt_mask;
        out_chip_sel  <= nxt_sel;
        out_chip_addr <= nxt_caddr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8,
  localparam int BYTE_W    = $clog2(WORD_BYTES),
  localparam int CA_W      = ADDR_W - BYTE_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [ADDR_W-1:0]     in_vaddr,
  input logic [ADDR_W-1:0]     cfg_base,
  input logic [ADDR_W-1:0]     cfg_limit,
  input logic [ADDR_W-1:0]     cfg_offset,
  input logic                  out_valid,
  input logic [ADDR_W-1:0]     out_paddr,
  input logic                  out_inseg,
  input logic                  out_cwf_ok,
  input logic [WORD_BYTES-1:0] out_chip_mask,
  input logic [BYTE_W-1:0]     out_chip_sel,
  input logic [CA_W-1:0]       out_chip_addr
);
  logic req_in;
  assign req_in = (in_vaddr >= cfg_base) && (in_vaddr < cfg_limit);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_paddr) && $stable(out_inseg) && $stable(out_chip_addr));
  a_r4_relocate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && req_in) |=> out_inseg &&
      (out_paddr == ADDR_W'($past(in_vaddr) + $past(cfg_offset))));
  a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !req_in) |=> !out_inseg && (out_paddr == $past(in_vaddr)));
  a_r6_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_inseg) |-> (&out_chip_mask));
  a_r7_one_chip: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inseg) |-> ($countones(out_chip_mask) == 1));
  a_r8_cwf: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cwf_ok != out_inseg));
  a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cfg_limit <= cfg_base)) |=> !out_inseg);
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
  .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_offset(cfg_offset),
  .out_valid(out_valid), .out_paddr(out_paddr), .out_inseg(out_inseg),
  .out_cwf_ok(out_cwf_ok), .out_chip_mask(out_chip_mask),
  .out_chip_sel(out_chip_sel), .out_chip_addr(out_chip_addr)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  localparam int AW   = 10;
  localparam int SPAN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_vaddr = '0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0, cfg_offset = '0;
  logic          out_valid, out_inseg, out_cwf_ok;
  logic [AW-1:0] out_paddr;
  logic [7:0]    out_chip_mask;
  logic [2:0]    out_chip_sel;
  logic [AW-4:0] out_chip_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_xlate #(.ADDR_W(AW), .WORD_BYTES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_offset(cfg_offset),
    .out_valid(out_valid), .out_paddr(out_paddr), .out_inseg(out_inseg),
    .out_cwf_ok(out_cwf_ok), .out_chip_mask(out_chip_mask),
    .out_chip_sel(out_chip_sel), .out_chip_addr(out_chip_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_and_check(input int v, input int b, input int l, input int o);
    bit hit;
    int p, sel, mask, ca;
    @(negedge clk);
    in_valid = 1'b1;
    in_vaddr = AW'(v);
    @(negedge clk);
    in_valid = 1'b0;
    hit = (v >= b) && (v < l);
    p = hit ? (v + o) % SPAN : v;
    if (hit) begin
      sel = (p / 8) % 8; mask = 1 << sel; ca = p / 64;
    end else begin
      sel = p % 8; mask = 255; ca = p / 8;
    end
    chk("R2 valid", int'(out_valid), 1);
    chk(l <= b ? "R9 empty inseg" : "R3 inseg", int'(out_inseg), int'(hit));
    chk(hit ? "R4 paddr" : "R5 paddr", int'(out_paddr), p);
    chk("R8 cwf", int'(out_cwf_ok), int'(!hit));
    chk(hit ? "R7 mask" : "R6 mask", int'(out_chip_mask), mask);
    chk(hit ? "R7 sel" : "R6 sel", int'(out_chip_sel), sel);
    chk(hit ? "R7 caddr" : "R6 caddr", int'(out_chip_addr), ca);
  endtask

  task automatic sweep(input int b, input int l, input int o);
    cfg_base = AW'(b); cfg_limit = AW'(l); cfg_offset = AW'(o);
    for (int v = 0; v < SPAN; v++) send_and_check(v, b, l, o);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    // R1: reset state before any request
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 paddr", int'(out_paddr), 0);
    chk("R1 mask", int'(out_chip_mask), 0);
    chk("R1 caddr", int'(out_chip_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle valid", int'(out_valid), 0);
    chk("R1 idle inseg", int'(out_inseg), 0);

    sweep('h0C8, 'h2A0, 'h250);   // relocation wraps past the top
    sweep('h000, 'h3FF, 'h008);   // window from zero, top address excluded
    sweep('h180, 'h180, 'h040);   // R9 empty window
    sweep('h300, 'h100, 'h040);   // R9 inverted window

    // R2: outputs hold while in_valid is low
    cfg_base = AW'('h100); cfg_limit = AW'('h200); cfg_offset = AW'('h010);
    send_and_check('h123, 'h100, 'h200, 'h010);
    held = int'(out_paddr);
    in_vaddr = AW'('h3F0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 no valid", int'(out_valid), 0);
    chk("R2 hold paddr", int'(out_paddr), held);
    chk("R2 hold inseg", int'(out_inseg), 1);
    summary();
  end
endmodule